// File: doc/BRIEF.md
# Bus Initiator Control Sequencer

This block sequences the control strobes on the initiator side of a multiplexed parallel bus. An internal client asks for an access by giving a burst length in data phases. The sequencer then runs an address cycle with the frame strobe low. It enters the data phases with the initiator-ready strobe low and waits for a target to claim the access with device-select. It counts completed phases as target-ready arrives. Frame stays low until the final phase is under way.

The access ends in one of four ways: normal completion, master abort when no target claims within the timeout, retry when the target stops before any data moved, or disconnect when the target stops after some data moved. Every strobe the block owns goes through a driven-high cycle before its output enable drops. The outcome and the number of phases not yet done are reported with a one-cycle done pulse. The address and data path and command decode sit outside this block.

Top module: `bus_init_seq`

## Requirements
- R1: While reset is held low and after it is released, both output enables are 0, frame and initiator-ready read 1, ready is 1, done is 0, status is 0 and remain is 0.
- R2: In idle, a request with a nonzero length starts an address cycle on the next clock: frame 0, initiator-ready 1, both enables 1. A request of length 0 is ignored and the block stays idle.
- R3: In every data cycle initiator-ready is 0. Frame is 0 while more than one phase is left and 1 during the final phase.
- R4: A data phase completes on a clock where initiator-ready, device-select and target-ready are all low. The remain output then drops by one.
- R5: After the final phase completes there is one cycle with frame released, initiator-ready driven 1, done 1, status 0 (complete) and remain 0. The next cycle is idle with both enables 0.
- R6: If device-select is not seen low in any of the TMO_CYC data cycles after the address cycle, the access ends with status 1 (master abort) and remain equal to the requested length.
- R7: Any abort or stop ends with one cycle of frame driven 1 and initiator-ready still 0. Then follows one cycle with frame released and initiator-ready driven 1 with done 1. Then comes idle.
- R8: A stop from a claiming target before any phase completed ends with status 2 (retry) and remain equal to the requested length.
- R9: A stop after at least one phase completed ends with status 3 (disconnect). Remain is then the number of phases not done, counting a phase that completes in the same cycle as the stop.
- R10: When target-ready completes the final phase in the same cycle that stop is asserted, the result is status 0 with remain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request to start an access |
| req_len_i | input | LEN_W | Number of data phases requested |
| req_ready_o | output | 1 | High while idle and able to accept |
| devsel_ni | input | 1 | Target device-select, active low |
| trdy_ni | input | 1 | Target-ready, active low |
| stop_ni | input | 1 | Target stop request, active low |
| frame_no | output | 1 | Frame strobe, active low |
| irdy_no | output | 1 | Initiator-ready strobe, active low |
| frame_oe_o | output | 1 | Output enable for frame |
| irdy_oe_o | output | 1 | Output enable for initiator-ready |
| done_o | output | 1 | One-cycle pulse when an access ends |
| status_o | output | 2 | Outcome: 0 complete, 1 abort, 2 retry, 3 disconnect |
| remain_o | output | LEN_W | Phases not yet completed |

## Verification
The bench builds the block with LEN_W of 3 and the default timeout of 5 cycles. Every burst length from 1 to 7 can then be crossed with every device-select arrival from the first data cycle to past the timeout, with and without target wait states. Stop is placed at each phase, with and without data in the stopping cycle. That sweep reaches the exact timeout edge, retry against disconnect, and the stop that coincides with the final phase.

// File: rtl/bus_init_pkg.sv
package bus_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WIND,
    ST_REL
  } seq_state_e;

  typedef enum logic [1:0] {
    STS_OK    = 2'd0,
    STS_ABORT = 2'd1,
    STS_RETRY = 2'd2,
    STS_DISC  = 2'd3
  } seq_status_e;
endpackage

// File: rtl/bus_init_tmo.sv
module bus_init_tmo #(
  parameter int unsigned TMO_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + CW'(1);
  end

  // fires in the last unclaimed window cycle
  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bus_init_drv.sv
module bus_init_drv
  import bus_init_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       last_i,
  output logic       frame_no,
  output logic       irdy_no,
  output logic       frame_oe_o,
  output logic       irdy_oe_o
);
  always_comb begin
    frame_no   = 1'b1;
    irdy_no    = 1'b1;
    frame_oe_o = 1'b0;
    irdy_oe_o  = 1'b0;
    unique case (state_i)
      ST_ADDR: begin
        frame_no   = 1'b0;
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
      end
      ST_DATA: begin
        frame_no   = last_i;
        irdy_no    = 1'b0;
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
      end
      ST_WIND: begin
        irdy_no    = 1'b0;
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
      end
      ST_REL: begin
        irdy_oe_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_init_seq.sv
module bus_init_seq
  import bus_init_pkg::*;
#(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned TMO_CYC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  input  logic             devsel_ni,
  input  logic             trdy_ni,
  input  logic             stop_ni,
  output logic             frame_no,
  output logic             irdy_no,
  output logic             frame_oe_o,
  output logic             irdy_oe_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [LEN_W-1:0] remain_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_state_e       state_q, state_d;
  seq_status_e      status_q, status_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic             claimed_q, claimed_d;
  logic             moved_q, moved_d;

  logic in_data, hit, xfer, stp, run, expire;

  assign in_data = (state_q == ST_DATA);
  assign hit     = in_data && !devsel_ni;
  assign xfer    = hit && !trdy_ni;
  assign stp     = hit && !stop_ni;
  assign run     = in_data && !claimed_q && devsel_ni;

  bus_init_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_ADDR),
    .run_i    (run),
    .expire_o (expire)
  );

  always_comb begin
    state_d   = state_q;
    status_d  = status_q;
    remain_d  = remain_q;
    claimed_d = claimed_q;
    moved_d   = moved_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i && (req_len_i != '0)) begin
          state_d   = ST_ADDR;
          remain_d  = req_len_i;
          claimed_d = 1'b0;
          moved_d   = 1'b0;
        end
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (xfer && (remain_q == ONE)) begin
          // final phase done: completion wins over a coincident stop
          remain_d = '0;
          status_d = STS_OK;
          state_d  = ST_REL;
        end else if (stp) begin
          remain_d = remain_q - (xfer ? ONE : '0);
          status_d = (moved_q || xfer) ? STS_DISC : STS_RETRY;
          state_d  = ST_WIND;
        end else if (expire) begin
          status_d = STS_ABORT;
          state_d  = ST_WIND;
        end else begin
          if (xfer) begin
            remain_d = remain_q - ONE;
            moved_d  = 1'b1;
          end
          if (hit) claimed_d = 1'b1;
        end
      end
      ST_WIND: state_d = ST_REL;
      ST_REL:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      status_q  <= STS_OK;
      remain_q  <= '0;
      claimed_q <= 1'b0;
      moved_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      status_q  <= status_d;
      remain_q  <= remain_d;
      claimed_q <= claimed_d;
      moved_q   <= moved_d;
    end
  end

  bus_init_drv u_drv (
    .state_i    (state_q),
    .last_i     (remain_q == ONE),
    .frame_no   (frame_no),
    .irdy_no    (irdy_no),
    .frame_oe_o (frame_oe_o),
    .irdy_oe_o  (irdy_oe_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_REL);
  assign status_o    = status_q;
  assign remain_o    = remain_q;
endmodule

// File: rtl/bus_init_seq_chk.sv
module bus_init_seq_chk #(
  parameter int unsigned LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             devsel_ni,
  input logic             trdy_ni,
  input logic             stop_ni,
  input logic             frame_no,
  input logic             irdy_no,
  input logic             frame_oe_o,
  input logic             irdy_oe_o,
  input logic             done_o,
  input logic [LEN_W-1:0] remain_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!frame_oe_o && !irdy_oe_o && !done_o)); // R1

  AST_ADDR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_oe_o) |-> (!frame_no && irdy_no && irdy_oe_o)); // R2

  AST_IRDY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_no && !irdy_no && !devsel_ni && trdy_ni && stop_ni) |=> !irdy_no); // R3

  AST_PHASE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_no && !irdy_no && !devsel_ni && !trdy_ni && stop_ni)
      |=> (remain_o == $past(remain_o) - LEN_W'(1))); // R4

  AST_DONE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!frame_oe_o && irdy_oe_o && irdy_no)); // R5

  AST_FRAME_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_oe_o) |-> (irdy_oe_o && irdy_no && $past(frame_no))); // R7

  AST_IRDY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irdy_oe_o) |-> (!frame_oe_o && $past(irdy_no))); // R7
endmodule

bind bus_init_seq bus_init_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .devsel_ni   (devsel_ni),
  .trdy_ni     (trdy_ni),
  .stop_ni     (stop_ni),
  .frame_no    (frame_no),
  .irdy_no     (irdy_no),
  .frame_oe_o  (frame_oe_o),
  .irdy_oe_o   (irdy_oe_o),
  .done_o      (done_o),
  .remain_o    (remain_o)
);

// File: tb/bus_init_seq_test.sv
module bus_init_seq_test;
  localparam int LW  = 3;
  localparam int TMO = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic          devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic          req_ready, frame_n, irdy_n, frame_oe, irdy_oe, done;
  logic [1:0]    status;
  logic [LW-1:0] remain;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_init_seq #(.LEN_W(LW), .TMO_CYC(TMO)) uut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_len_i (req_len), .req_ready_o (req_ready),
    .devsel_ni (devsel_n), .trdy_ni (trdy_n), .stop_ni (stop_n),
    .frame_no (frame_n), .irdy_no (irdy_n),
    .frame_oe_o (frame_oe), .irdy_oe_o (irdy_oe),
    .done_o (done), .status_o (status), .remain_o (remain)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_idle();
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
  endtask

  // sp: phase number at which stop is raised (0 = never); spd: target-ready with stop
  task automatic run(input int len, input int dly, input int ws, input int sp, input int spd);
    int left, xf, cyc, outc;
    bit claimed, dv, tr, st, saw_stop;
    string tag;
    req_valid = 1'b1;
    req_len   = LW'(len);
    step();
    req_valid = 1'b0;
    check({frame_n, irdy_n, frame_oe, irdy_oe} == 4'b0111, "R2",
          int'({frame_n, irdy_n, frame_oe, irdy_oe}), 7);
    step();
    left = len; xf = 0; cyc = 0; outc = -1; claimed = 0; saw_stop = 0;
    while (outc < 0) begin
      cyc++;
      check({frame_n, irdy_n} == {left == 1, 1'b0}, "R3",
            int'({frame_n, irdy_n}), int'({left == 1, 1'b0}));
      check(int'(remain) == left, "R4", int'(remain), left);
      dv = claimed || (dly != 0 && cyc >= dly);
      tr = dv && (ws == 0 || (cyc % 2) == 0);
      st = dv && sp != 0 && (xf + 1 == sp);
      if (st) tr = (spd != 0);
      devsel_n = !dv; trdy_n = !tr; stop_n = !st;
      step();
      if (dv) claimed = 1;
      if (tr) begin xf++; left--; end
      if (left == 0) begin outc = 0; saw_stop = st; end
      else if (st) outc = (xf > 0) ? 3 : 2;
      else if (!claimed && cyc == TMO) outc = 1;
    end
    bus_idle();
    if (outc != 0) begin
      check({frame_n, irdy_n, frame_oe, irdy_oe} == 4'b1011, "R7",
            int'({frame_n, irdy_n, frame_oe, irdy_oe}), 11);
      step();
    end
    check({frame_oe, irdy_oe, irdy_n, done} == 4'b0111,
          (outc == 0) ? "R5" : "R7",
          int'({frame_oe, irdy_oe, irdy_n, done}), 7);
    case (outc)
      0: tag = saw_stop ? "R10" : "R5";
      1: tag = "R6";
      2: tag = "R8";
      default: tag = "R9";
    endcase
    check(int'(status) == outc, tag, int'(status), outc);
    check(int'(remain) == left, tag, int'(remain), left);
    step();
    check({frame_oe, irdy_oe, req_ready, done} == 4'b0010, "R5",
          int'({frame_oe, irdy_oe, req_ready, done}), 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bus_idle();
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check({frame_oe, irdy_oe, frame_n, irdy_n, req_ready, done} == 6'b001110, "R1",
          int'({frame_oe, irdy_oe, frame_n, irdy_n, req_ready, done}), 14);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check({frame_oe, irdy_oe, frame_n, irdy_n, req_ready, done} == 6'b001110, "R1",
          int'({frame_oe, irdy_oe, frame_n, irdy_n, req_ready, done}), 14);
    check(status == 2'd0 && remain == '0, "R1", int'({status, remain}), 0);

    // zero-length request must not start anything (R2)
    req_valid = 1'b1;
    req_len   = '0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(!frame_oe && !irdy_oe && req_ready, "R2",
            int'({frame_oe, irdy_oe, req_ready}), 1);
    end
    req_valid = 1'b0;
    step();

    for (int len = 1; len < (1 << LW); len++)
      for (int dly = 0; dly <= TMO + 1; dly++)
        for (int ws = 0; ws < 2; ws++)
          for (int sp = 0; sp <= len; sp++)
            for (int spd = 0; spd < 2; spd++)
              if (!(sp == 0 && spd == 1)) run(len, dly, ws, sp, spd);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule